// File: doc/BRIEF.md
# DRAM Row Boundary Decoder

This block takes a physical address and works out which of eight DRAM rows it falls into. Software programs one boundary byte per row. Each boundary is a running total: it gives the end of that row and all rows before it, counted in 8 MB units. A row that is not populated repeats the total of the row before it, so it covers no addresses.

For each request the decoder returns the row index and a hit flag. It also returns the offset of the address within the row, and the page-size code and bank count programmed for that row. A reserved page-size code on the selected row raises a configuration error. The result is registered, so it appears one clock after the request. A parameter can make the path purely combinational instead. Row count, address width, boundary width and the unit size are all parameters.

Top module: `row_bound_decoder`

## Requirements
- R1: `rsp_valid` equals `req_valid` delayed by one clock, and reset clears every output to zero.
- R2: On a hit, `rsp_row` is the lowest row n whose boundary is strictly greater than the address bits above the unit size (`req_addr[ADDR_W-1:23]` by default), and `rsp_hit` is 1.
- R3: A row whose boundary equals the boundary of the row before it is never selected. For row 0, this means a boundary of zero.
- R4: When no boundary is greater than the upper address bits, `rsp_hit` is 0 and `rsp_row`, `rsp_offset`, `rsp_page`, `rsp_four_bank` and `rsp_cfg_err` are all 0.
- R5: On a hit, `rsp_offset` is the address minus the previous row's boundary times 8 MB. For row 0 the previous boundary is taken as zero.
- R6: `rsp_page` is `page_map[2n+1:2n]` for the selected row n. The codes are 00 for 2 KB, 01 for 4 KB, 10 for 8 KB and 11 reserved.
- R7: `rsp_four_bank` is `bank_map[n]` for the selected row n, where 1 means four banks and 0 means two banks.
- R8: `rsp_cfg_err` is 1 exactly when there is a hit and the selected row's page code is 11.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request strobe |
| req_addr | input | ADDR_W | Physical address to decode |
| bnd_flat | input | NUM_ROWS*BND_W | Cumulative row boundaries; row n is at bits [BND_W*n +: BND_W] |
| page_map | input | 2*NUM_ROWS | Page-size code per row; row n is at bits [2n+1:2n] |
| bank_map | input | NUM_ROWS | Bank count per row; bit n is for row n |
| rsp_valid | output | 1 | Result strobe |
| rsp_hit | output | 1 | The address falls inside a populated row |
| rsp_row | output | $clog2(NUM_ROWS) | Selected row index |
| rsp_offset | output | ADDR_W | Offset of the address within the selected row |
| rsp_page | output | 2 | Page-size code of the selected row |
| rsp_four_bank | output | 1 | Selected row has four banks |
| rsp_cfg_err | output | 1 | Selected row carries the reserved page-size code |

## Verification
Every value of the upper address bits is swept against five boundary layouts, with the low address bits varied as well:
- **Empty rows between populated ones** test that equal boundaries are skipped.
- **All rows empty** tests the miss path.
- **Only the last row populated** tests selection past seven empty rows, together with a reserved page code.
- **Equal-sized rows** test the exact edge at each boundary.
- **A final boundary of 255** tests the largest boundary value.

Page and bank maps differ between layouts, so a wrong field index gives a wrong output.

// File: rtl/rbd_pkg.sv
package rbd_pkg;

   typedef enum logic [1:0] {
      PG_2K   = 2'b00,
      PG_4K   = 2'b01,
      PG_8K   = 2'b10,
      PG_RSVD = 2'b11
   } page_code_e;

   function automatic int unsigned max_u(input int unsigned a, input int unsigned b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/rbd_compare.sv
// Per-row "boundary above address" flags.
module rbd_compare #(
   parameter int unsigned NUM_ROWS = 8,
   parameter int unsigned BND_W    = 8,
   parameter int unsigned HI_W     = 9,
   parameter int unsigned CMP_W    = 9
) (
   input  logic [HI_W-1:0]           addr_hi,
   input  logic [NUM_ROWS*BND_W-1:0] bnd_flat,
   output logic [NUM_ROWS-1:0]       above
);

   for (genvar n = 0; n < NUM_ROWS; n++) begin : g_row
      logic [CMP_W-1:0] bnd_c;
      logic [CMP_W-1:0] hi_c;
      assign bnd_c    = CMP_W'(bnd_flat[n*BND_W +: BND_W]);
      assign hi_c     = CMP_W'(addr_hi);
      assign above[n] = (bnd_c > hi_c);
   end

endmodule

// File: rtl/rbd_priority.sv
// Lowest-index-wins encoder.
module rbd_priority #(
   parameter int unsigned NUM_ROWS = 8,
   localparam int unsigned IDX_W   = $clog2(NUM_ROWS)
) (
   input  logic [NUM_ROWS-1:0] req,
   output logic [IDX_W-1:0]    idx,
   output logic                any
);

   always_comb begin
      idx = '0;
      for (int i = NUM_ROWS - 1; i >= 0; i--) begin
         if (req[i]) idx = IDX_W'(i);
      end
   end

   assign any = |req;

endmodule

// File: rtl/rbd_select.sv
// Picks the per-row fields and forms the row-local offset.
module rbd_select
   import rbd_pkg::*;
#(
   parameter int unsigned NUM_ROWS = 8,
   parameter int unsigned BND_W    = 8,
   parameter int unsigned ADDR_W   = 32,
   parameter int unsigned UNIT_LG2 = 23,
   localparam int unsigned IDX_W   = $clog2(NUM_ROWS),
   localparam int unsigned HI_W    = ADDR_W - UNIT_LG2,
   localparam int unsigned CMP_W   = max_u(HI_W, BND_W)
) (
   input  logic [ADDR_W-1:0]         addr,
   input  logic [NUM_ROWS*BND_W-1:0] bnd_flat,
   input  logic [2*NUM_ROWS-1:0]     page_map,
   input  logic [NUM_ROWS-1:0]       bank_map,
   input  logic [IDX_W-1:0]          idx,
   input  logic                      any,
   output logic                      hit,
   output logic [IDX_W-1:0]          row,
   output logic [ADDR_W-1:0]         offset,
   output logic [1:0]                page,
   output logic                      four_bank,
   output logic                      cfg_err
);

   logic [BND_W-1:0]  base;
   logic [CMP_W-1:0]  base_c;
   logic [HI_W-1:0]   hi_delta;
   logic [1:0]        page_raw;
   logic              bank_raw;

   always_comb begin
      base     = '0;
      page_raw = page_map[1:0];
      bank_raw = bank_map[0];
      for (int n = 1; n < NUM_ROWS; n++) begin
         if (IDX_W'(n) == idx) begin
            base     = bnd_flat[(n-1)*BND_W +: BND_W];
            page_raw = page_map[2*n +: 2];
            bank_raw = bank_map[n];
         end
      end
   end

   // The previous boundary never exceeds the upper address bits on a hit,
   // so truncating it to HI_W bits loses nothing.
   assign base_c   = CMP_W'(base);
   assign hi_delta = addr[ADDR_W-1:UNIT_LG2] - base_c[HI_W-1:0];

   assign hit       = any;
   assign row       = any ? idx : '0;
   assign offset    = any ? {hi_delta, addr[UNIT_LG2-1:0]} : '0;
   assign page      = any ? page_raw : 2'b00;
   assign four_bank = any & bank_raw;
   assign cfg_err   = any & (page_code_e'(page_raw) == PG_RSVD);

endmodule

// File: rtl/row_bound_decoder.sv
module row_bound_decoder
   import rbd_pkg::*;
#(
   parameter int unsigned NUM_ROWS = 8,
   parameter int unsigned BND_W    = 8,
   parameter int unsigned ADDR_W   = 32,
   parameter int unsigned UNIT_LG2 = 23,
   parameter bit          REG_OUT  = 1'b1,
   localparam int unsigned IDX_W   = $clog2(NUM_ROWS),
   localparam int unsigned HI_W    = ADDR_W - UNIT_LG2,
   localparam int unsigned CMP_W   = max_u(HI_W, BND_W)
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      req_valid,
   input  logic [ADDR_W-1:0]         req_addr,
   input  logic [NUM_ROWS*BND_W-1:0] bnd_flat,
   input  logic [2*NUM_ROWS-1:0]     page_map,
   input  logic [NUM_ROWS-1:0]       bank_map,
   output logic                      rsp_valid,
   output logic                      rsp_hit,
   output logic [IDX_W-1:0]          rsp_row,
   output logic [ADDR_W-1:0]         rsp_offset,
   output logic [1:0]                rsp_page,
   output logic                      rsp_four_bank,
   output logic                      rsp_cfg_err
);

   if (NUM_ROWS < 2) begin : g_bad_rows
      $error("row_bound_decoder: NUM_ROWS must be at least 2");
   end
   if (UNIT_LG2 < 1 || ADDR_W <= UNIT_LG2) begin : g_bad_unit
      $error("row_bound_decoder: ADDR_W must exceed UNIT_LG2, which must be >= 1");
   end
   if (BND_W < 1) begin : g_bad_bnd
      $error("row_bound_decoder: BND_W must be at least 1");
   end

   logic [NUM_ROWS-1:0] above;
   logic [IDX_W-1:0]    sel_idx;
   logic                sel_any;
   logic                c_hit;
   logic [IDX_W-1:0]    c_row;
   logic [ADDR_W-1:0]   c_offset;
   logic [1:0]          c_page;
   logic                c_four;
   logic                c_err;

   rbd_compare #(
      .NUM_ROWS(NUM_ROWS), .BND_W(BND_W), .HI_W(HI_W), .CMP_W(CMP_W)
   ) u_cmp (
      .addr_hi  (req_addr[ADDR_W-1:UNIT_LG2]),
      .bnd_flat (bnd_flat),
      .above    (above)
   );

   rbd_priority #(.NUM_ROWS(NUM_ROWS)) u_pri (
      .req (above),
      .idx (sel_idx),
      .any (sel_any)
   );

   rbd_select #(
      .NUM_ROWS(NUM_ROWS), .BND_W(BND_W), .ADDR_W(ADDR_W), .UNIT_LG2(UNIT_LG2)
   ) u_sel (
      .addr      (req_addr),
      .bnd_flat  (bnd_flat),
      .page_map  (page_map),
      .bank_map  (bank_map),
      .idx       (sel_idx),
      .any       (sel_any),
      .hit       (c_hit),
      .row       (c_row),
      .offset    (c_offset),
      .page      (c_page),
      .four_bank (c_four),
      .cfg_err   (c_err)
   );

   if (REG_OUT) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            rsp_valid     <= 1'b0;
            rsp_hit       <= 1'b0;
            rsp_row       <= '0;
            rsp_offset    <= '0;
            rsp_page      <= 2'b00;
            rsp_four_bank <= 1'b0;
            rsp_cfg_err   <= 1'b0;
         end else begin
            rsp_valid     <= req_valid;
            rsp_hit       <= c_hit;
            rsp_row       <= c_row;
            rsp_offset    <= c_offset;
            rsp_page      <= c_page;
            rsp_four_bank <= c_four;
            rsp_cfg_err   <= c_err;
         end
      end

      // Snapshot of the inputs behind the current result, for the checks only.
      logic [NUM_ROWS*BND_W-1:0] chk_bnd;
      logic [HI_W-1:0]           chk_hi;
      logic [2*NUM_ROWS-1:0]     chk_page;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            chk_bnd  <= '0;
            chk_hi   <= '0;
            chk_page <= '0;
         end else begin
            chk_bnd  <= bnd_flat;
            chk_hi   <= req_addr[ADDR_W-1:UNIT_LG2];
            chk_page <= page_map;
         end
      end

      logic [CMP_W-1:0]  chk_cur;
      logic [CMP_W-1:0]  chk_prv;
      logic [CMP_W-1:0]  chk_hi_c;
      logic [ADDR_W-1:0] chk_span;
      logic [1:0]        chk_code;
      always_comb begin
         chk_cur  = '0;
         chk_prv  = '0;
         chk_code = 2'b00;
         for (int n = 0; n < NUM_ROWS; n++) begin
            if (IDX_W'(n) == rsp_row) begin
               chk_cur  = CMP_W'(chk_bnd[n*BND_W +: BND_W]);
               chk_code = chk_page[2*n +: 2];
               if (n > 0) chk_prv = CMP_W'(chk_bnd[(n-1)*BND_W +: BND_W]);
            end
         end
      end
      assign chk_hi_c = CMP_W'(chk_hi);
      assign chk_span = ADDR_W'(chk_cur) - ADDR_W'(chk_prv);

      // R1
      valid_delay_chk: assert property (@(posedge clk) disable iff (!rst_n)
         rsp_valid |-> $past(req_valid));
      // R2
      row_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
         rsp_hit |-> (chk_cur > chk_hi_c));
      // R3
      lowest_row_chk: assert property (@(posedge clk) disable iff (!rst_n)
         rsp_hit |-> (chk_prv <= chk_hi_c));
      // R4
      miss_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
         !rsp_hit |-> (rsp_row == '0 && rsp_offset == '0 && rsp_page == 2'b00
                       && !rsp_four_bank && !rsp_cfg_err));
      // R5
      offset_span_chk: assert property (@(posedge clk) disable iff (!rst_n)
         rsp_hit |-> ((rsp_offset >> UNIT_LG2) < chk_span));
      // R6
      page_field_chk: assert property (@(posedge clk) disable iff (!rst_n)
         rsp_hit |-> (rsp_page == chk_code));
      // R8
      cfg_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
         rsp_cfg_err |-> (rsp_hit && rsp_page == 2'b11));
   end else begin : g_comb
      assign rsp_valid     = req_valid;
      assign rsp_hit       = c_hit;
      assign rsp_row       = c_row;
      assign rsp_offset    = c_offset;
      assign rsp_page      = c_page;
      assign rsp_four_bank = c_four;
      assign rsp_cfg_err   = c_err;
   end

endmodule

// File: tb/test_row_bound_decoder.sv
`timescale 1ns/1ps
module test_row_bound_decoder;

   localparam int NR = 8;
   localparam int BW = 8;
   localparam int AW = 32;
   localparam int UL = 23;
   localparam int HW = AW - UL;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic            req_valid = 1'b0;
   logic [AW-1:0]   req_addr = '0;
   logic [NR*BW-1:0] bnd_flat = '0;
   logic [2*NR-1:0] page_map = '0;
   logic [NR-1:0]   bank_map = '0;
   logic            rsp_valid, rsp_hit, rsp_four_bank, rsp_cfg_err;
   logic [2:0]      rsp_row;
   logic [AW-1:0]   rsp_offset;
   logic [1:0]      rsp_page;

   int n_vec  = 0;
   int n_fail = 0;

   always #2.5 clk = ~clk;

   row_bound_decoder i_row_bound_decoder (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
      .bnd_flat(bnd_flat), .page_map(page_map), .bank_map(bank_map),
      .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_row(rsp_row),
      .rsp_offset(rsp_offset), .rsp_page(rsp_page),
      .rsp_four_bank(rsp_four_bank), .rsp_cfg_err(rsp_cfg_err)
   );

   task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
      n_vec++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h addr=%08h", tag, act, exp, req_addr);
      end
   endtask

   function automatic int bnd_of(input int n);
      return int'(bnd_flat[n*BW +: BW]);
   endfunction

   // Apply one address; compare the registered result one clock later.
   task automatic apply(input int hi, input int lo);
      int exp_row, prev, cur, code;
      bit exp_hit;
      logic [AW-1:0] exp_off;
      req_addr  = {HW'(hi), UL'(lo)};
      req_valid = 1'b1;
      exp_hit = 1'b0; exp_row = 0;
      for (int n = NR - 1; n >= 0; n--)
         if (bnd_of(n) > hi) begin exp_hit = 1'b1; exp_row = n; end
      prev = (exp_hit && exp_row > 0) ? bnd_of(exp_row - 1) : 0;
      cur  = bnd_of(exp_row);
      code = exp_hit ? int'(page_map[2*exp_row +: 2]) : 0;
      exp_off = exp_hit ? (AW'(req_addr) - (AW'(prev) << UL)) : '0;
      @(negedge clk);
      check("R1 valid", 64'(rsp_valid), 64'd1);
      if (exp_hit) begin
         check("R2 hit", 64'(rsp_hit), 64'd1);
         check("R2 row", 64'(rsp_row), 64'(exp_row));
         // R3: selected row must have non-zero size
         check("R3 nonempty", 64'(cur > prev), 64'd1);
         check("R5 offset", 64'(rsp_offset), 64'(exp_off));
         check("R6 page", 64'(rsp_page), 64'(code));
         check("R7 banks", 64'(rsp_four_bank), 64'(bank_map[exp_row]));
         check("R8 err", 64'(rsp_cfg_err), 64'(code == 3));
      end else begin
         check("R4 miss", {rsp_hit, rsp_row, rsp_offset, rsp_page, rsp_four_bank, rsp_cfg_err}, 64'd0);
      end
   endtask

   task automatic load(input int b0, b1, b2, b3, b4, b5, b6, b7,
                       input logic [15:0] pg, input logic [7:0] bk);
      bnd_flat = {BW'(b7), BW'(b6), BW'(b5), BW'(b4), BW'(b3), BW'(b2), BW'(b1), BW'(b0)};
      page_map = pg;
      bank_map = bk;
   endtask

   task automatic sweep(input int seed);
      for (int h = 0; h < (1 << HW); h++)
         apply(h, (h * 40503 + seed * 7919) & ((1 << UL) - 1));
   endtask

   initial begin : watchdog
      #(5.0 * 150000);
      n_fail++;
      $display("FAIL watchdog expired");
      $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      // R1: reset state
      check("R1 reset", {rsp_valid, rsp_hit, rsp_row, rsp_offset, rsp_page, rsp_four_bank, rsp_cfg_err}, 64'd0);
      rst_n = 1'b1;
      @(negedge clk);

      // empty rows interleaved with populated rows
      load(2, 2, 6, 22, 22, 23, 31, 31, 16'b1110_0100_1110_0100, 8'b1010_0101);
      sweep(1);
      // all rows empty
      load(0, 0, 0, 0, 0, 0, 0, 0, 16'hFFFF, 8'hFF);
      sweep(2);
      // only last row populated, reserved code there
      load(0, 0, 0, 0, 0, 0, 0, 16, 16'hC000, 8'h80);
      sweep(3);
      // equal-sized rows
      load(16, 32, 48, 64, 80, 96, 112, 128, 16'b0110_0001_1000_0110, 8'b0110_1001);
      sweep(4);
      // largest boundary value
      load(1, 2, 3, 4, 5, 6, 7, 255, 16'b1011_0001_1110_0100, 8'b1100_0011);
      sweep(5);

      // R1: response strobe drops one clock after the request does
      req_valid = 1'b0;
      @(negedge clk);
      check("R1 idle", 64'(rsp_valid), 64'd0);

      $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
      $finish;
   end

endmodule